// File: doc/BRIEF.md
# Host Bus DMA Handshake Front End

This block sits between an ISA-style host bus and the byte-transfer engine of a peripheral. The host read strobe, write strobe, DMA acknowledge and terminal-count input are asynchronous to the block clock. The block passes each of them through a two-flop synchronizer and detects edges on the synchronized copies. When a read or write strobe falls, the block captures the ten-bit I/O address and compares it with a programmable base. It issues a one-clock register select pulse only when Address Enable is low, so that only programmed I/O cycles reach the register file.

When the peripheral signals that a byte is ready, or that it needs one, the block raises an active-high DMA request. The way the request is later dropped depends on the acknowledge. If the acknowledge was high when the request was raised, the request drops when the acknowledge falls. If the acknowledge was already low (demand mode), the request drops when the read strobe falls. During an acknowledged cycle, each strobe produces a DMA read or write pulse with no address decode. The block also watches the terminal-count input while an acknowledge is low. A mode input sets its polarity. A valid terminal count gives a single completion pulse and disarms the request logic until the engine re-arms it.

The bidirectional data bus is modelled as separate data-in, data-out and output-enable signals.

Top module: `hbus_dma_front`

## Requirements
- R1: While reset is held low at a clock edge and after it is released, `drq`, `data_oe`, `reg_rd_pulse`, `reg_wr_pulse`, `dma_rd_pulse`, `dma_wr_pulse` and `tc_done` are all 0.
- R2: A falling read strobe with `aen` low and `addr[9:3] == io_base[9:3]` gives exactly one `reg_rd_pulse`. The accompanying `reg_idx` equals `addr[2:0]` as captured when the strobe fell.
- R3: A falling write strobe under the same conditions gives exactly one `reg_wr_pulse`. It carries `reg_idx = addr[2:0]` and `reg_wdata` equal to `host_din` as sampled when the strobe fell.
- R4: If `aen` is high, or if `addr[9:3]` differs from `io_base[9:3]`, a strobe gives no register pulse.
- R5: `data_oe` is 1 only while the read strobe is low in a qualified read cycle. A qualified read cycle is either a decoded programmed read or a read with the acknowledge low. While `data_oe` is 1, `host_dout` equals `per_rdata`. `data_oe` returns to 0 after the read strobe rises.
- R6: A one-clock `byte_req` pulse while the engine is armed sets `drq` to 1 on the next clock edge.
- R7: If `dack_n` was high when `drq` was raised, `drq` stays high until the synchronized `dack_n` falls, and is then cleared.
- R8: If `dack_n` was already low when `drq` was raised (demand mode), `drq` stays high while the acknowledge stays low. It is cleared when the synchronized read strobe falls.
- R9: While `dack_n` is low, a falling read or write strobe gives one `dma_rd_pulse` or `dma_wr_pulse` respectively, whatever the address or `aen`.
- R10: The terminal-count input has no effect while `dack_n` is high. It gives no `tc_done` and does not disarm the request logic.
- R11: `tc_pol` = 0 makes `tc_in` active high and `tc_pol` = 1 makes it active low. An active terminal count while `dack_n` is low gives exactly one `tc_done` pulse per acknowledged period.
- R12: After `tc_done`, a `byte_req` does not raise `drq` until a `rearm` pulse has been given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ior_n | input | 1 | Host read strobe, active low, asynchronous |
| iow_n | input | 1 | Host write strobe, active low, asynchronous |
| aen | input | 1 | Address Enable, high during DMA cycles |
| addr | input | 10 | Host I/O address |
| io_base | input | 10 | Programmed decode base; bits 9:3 are compared |
| host_din | input | 8 | Data driven by the host on writes |
| host_dout | output | 8 | Data the block drives onto the bus |
| data_oe | output | 1 | Output enable for the data bus |
| dack_n | input | 1 | DMA acknowledge, active low, asynchronous |
| tc_in | input | 1 | Terminal count, polarity set by `tc_pol` |
| tc_pol | input | 1 | 0: terminal count active high; 1: active low |
| byte_req | input | 1 | One-clock pulse: peripheral has or needs a byte |
| rearm | input | 1 | One-clock pulse: allow requests again after completion |
| per_rdata | input | 8 | Read data from the register file or peripheral |
| reg_rd_pulse | output | 1 | One-clock programmed register read |
| reg_wr_pulse | output | 1 | One-clock programmed register write |
| reg_idx | output | 3 | Register index from the low address bits |
| reg_wdata | output | 8 | Write data captured with the write pulse |
| dma_rd_pulse | output | 1 | One-clock DMA read during an acknowledged cycle |
| dma_wr_pulse | output | 1 | One-clock DMA write during an acknowledged cycle |
| drq | output | 1 | DMA request, active high |
| tc_done | output | 1 | One-clock transfer-complete pulse |

## Verification
The hardest case to reach is demand mode. Here the request has to be raised while the synchronized acknowledge is already low, and it must then survive the acknowledge instead of being dropped by it. The stimulus holds `dack_n` low for longer than the synchronizer delay and only then pulses `byte_req`. It confirms that `drq` stays high for several cycles and then lowers the read strobe. It expects `drq` to clear exactly three clock edges after the strobe change, together with a DMA read pulse. The completion path is reached by asserting terminal count inside an acknowledged period in each polarity. The bench then shows that a later `byte_req` leaves `drq` low until `rearm` is pulsed.

// File: rtl/hbd_pkg.sv
// Shared widths and helpers for the host bus DMA front end.
package hbd_pkg;
    localparam int unsigned HBD_ADDR_W = 10;
    localparam int unsigned HBD_DATA_W = 8;
    localparam int unsigned HBD_IDX_W  = 3;

    // Terminal-count polarity selection.
    typedef enum logic {
        TC_ACT_HIGH = 1'b0,
        TC_ACT_LOW  = 1'b1
    } tc_pol_e;

    // Returns 1 when the synchronized terminal-count level is in its active state.
    function automatic logic tc_is_active(input logic lvl, input tc_pol_e pol);
        return (pol == TC_ACT_LOW) ? ~lvl : lvl;
    endfunction
endpackage

// File: rtl/hbd_sync.sv
// Two-flop synchronizer with a third stage for falling-edge detection.
// Assumes: each input bit is asynchronous and independent; RST_VAL gives idle levels.
module hbd_sync #(
    parameter int unsigned W       = 4,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] lvl,
    output logic [W-1:0] fall
);
    logic [W-1:0] meta_q, sync_q, prev_q;

    // Move the inputs into the clock domain and keep one delayed copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
            prev_q <= RST_VAL;
        end else begin
            meta_q <= async_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign lvl  = sync_q;
    assign fall = prev_q & ~sync_q;
endmodule

// File: rtl/hbd_decode.sv
// Programmed I/O address decode: captures address and write data on a strobe
// falling edge and issues a one-clock register read or write pulse.
// Assumes: addr, aen and wdata are stable while the strobe edge is synchronized.
module hbd_decode #(
    parameter int unsigned ADDR_W = hbd_pkg::HBD_ADDR_W,
    parameter int unsigned DATA_W = hbd_pkg::HBD_DATA_W,
    parameter int unsigned IDX_W  = hbd_pkg::HBD_IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] io_base,
    input  logic              aen,
    input  logic [DATA_W-1:0] wdata_in,
    input  logic              rd_fall,
    input  logic              wr_fall,
    output logic              pio_hit,
    output logic              reg_rd,
    output logic              reg_wr,
    output logic [IDX_W-1:0]  reg_idx,
    output logic [DATA_W-1:0] reg_wdata
);
    localparam int unsigned CMP_W = ADDR_W - IDX_W;

    logic [CMP_W-1:0] win_addr, win_base;

    assign win_addr = addr[ADDR_W-1:IDX_W];
    assign win_base = io_base[ADDR_W-1:IDX_W];
    // Address is in the window and the cycle is not a DMA cycle.
    assign pio_hit  = !aen && (win_addr == win_base);

    // Capture address and data at the strobe edge and emit the select pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rd    <= 1'b0;
            reg_wr    <= 1'b0;
            reg_idx   <= '0;
            reg_wdata <= '0;
        end else begin
            reg_rd <= rd_fall && pio_hit;
            reg_wr <= wr_fall && pio_hit;
            if (rd_fall || wr_fall) begin
                reg_idx <= addr[IDX_W-1:0];
            end
            if (wr_fall) begin
                reg_wdata <= wdata_in;
            end
        end
    end

    AST_REG_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> !reg_rd);  // R2
    AST_REG_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr);  // R3
endmodule

// File: rtl/hbd_dreq.sv
// DMA request and terminal-count logic.
// Assumes: byte_req and rearm are one-clock pulses; dack/ior inputs already synchronized.
module hbd_dreq (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_req,
    input  logic             rearm,
    input  logic             dack_lo,
    input  logic             dack_fall,
    input  logic             ior_fall,
    input  logic             tc_lvl,
    input  hbd_pkg::tc_pol_e tc_pol,
    output logic             drq,
    output logic             tc_done
);
    import hbd_pkg::*;

    logic demand_q;   // acknowledge was already low when the request was raised
    logic armed_q;    // requests allowed
    logic tc_seen_q;  // completion already reported in this acknowledged period
    logic tc_hit, drq_set, drq_clr;

    assign tc_hit  = dack_lo && tc_is_active(tc_lvl, tc_pol) && !tc_seen_q;
    assign drq_set = byte_req && armed_q && !drq;
    assign drq_clr = drq && (demand_q ? ior_fall : dack_fall);

    // Request set/clear with demand-mode tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drq      <= 1'b0;
            demand_q <= 1'b0;
        end else if (drq_clr) begin
            drq <= 1'b0;
        end else if (drq_set) begin
            drq      <= 1'b1;
            demand_q <= dack_lo;
        end
    end

    // Terminal-count capture, one pulse per acknowledged period, and arming.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tc_done   <= 1'b0;
            tc_seen_q <= 1'b0;
            armed_q   <= 1'b1;
        end else begin
            tc_done   <= tc_hit;
            tc_seen_q <= dack_lo && (tc_seen_q || tc_hit);
            if (rearm) begin
                armed_q <= 1'b1;
            end else if (tc_hit) begin
                armed_q <= 1'b0;
            end
        end
    end

    AST_DRQ_ACK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (drq && !demand_q && dack_fall) |=> !drq);  // R7
    AST_DRQ_DEMAND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (drq && demand_q && !ior_fall) |=> drq);  // R8
    AST_TC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        tc_done |-> $past(dack_lo));  // R10
    AST_TC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tc_done |=> !tc_done);  // R11
    AST_DISARMED_NO_DRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed_q && !rearm && !drq) |=> !drq);  // R12
endmodule

// File: rtl/hbus_dma_front.sv
// Host bus DMA handshake front end: synchronizes bus controls, decodes programmed
// I/O, produces DMA data pulses, the DMA request and the completion pulse.
// Assumes: host holds address, aen and write data stable around each strobe edge.
module hbus_dma_front #(
    parameter int unsigned ADDR_W = hbd_pkg::HBD_ADDR_W,
    parameter int unsigned DATA_W = hbd_pkg::HBD_DATA_W,
    parameter int unsigned IDX_W  = hbd_pkg::HBD_IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ior_n,
    input  logic              iow_n,
    input  logic              aen,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] io_base,
    input  logic [DATA_W-1:0] host_din,
    output logic [DATA_W-1:0] host_dout,
    output logic              data_oe,
    input  logic              dack_n,
    input  logic              tc_in,
    input  logic              tc_pol,
    input  logic              byte_req,
    input  logic              rearm,
    input  logic [DATA_W-1:0] per_rdata,
    output logic              reg_rd_pulse,
    output logic              reg_wr_pulse,
    output logic [IDX_W-1:0]  reg_idx,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              dma_rd_pulse,
    output logic              dma_wr_pulse,
    output logic              drq,
    output logic              tc_done
);
    import hbd_pkg::*;

    // Synchronized bit order: 0 read strobe, 1 write strobe, 2 acknowledge, 3 terminal count.
    localparam int unsigned NSYNC = 4;
    logic [NSYNC-1:0] s_lvl, s_fall;
    logic ior_hi, ior_fall, iow_fall, dack_lo, dack_fall, tc_lvl;
    logic pio_hit, oe_q;
    logic unused_sync;

    hbd_sync #(.W(NSYNC), .RST_VAL(4'b0111)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({tc_in, dack_n, iow_n, ior_n}),
        .lvl      (s_lvl),
        .fall     (s_fall)
    );

    assign ior_hi      = s_lvl[0];
    assign ior_fall    = s_fall[0];
    assign iow_fall    = s_fall[1];
    assign dack_lo     = ~s_lvl[2];
    assign dack_fall   = s_fall[2];
    assign tc_lvl      = s_lvl[3];
    assign unused_sync = ^{s_lvl[1], s_fall[3]};

    hbd_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (addr),
        .io_base   (io_base),
        .aen       (aen),
        .wdata_in  (host_din),
        .rd_fall   (ior_fall),
        .wr_fall   (iow_fall),
        .pio_hit   (pio_hit),
        .reg_rd    (reg_rd_pulse),
        .reg_wr    (reg_wr_pulse),
        .reg_idx   (reg_idx),
        .reg_wdata (reg_wdata)
    );

    hbd_dreq u_dreq (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_req  (byte_req),
        .rearm     (rearm),
        .dack_lo   (dack_lo),
        .dack_fall (dack_fall),
        .ior_fall  (ior_fall),
        .tc_lvl    (tc_lvl),
        .tc_pol    (tc_pol_e'(tc_pol)),
        .drq       (drq),
        .tc_done   (tc_done)
    );

    // Acknowledged-cycle data pulses, no address decode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dma_rd_pulse <= 1'b0;
            dma_wr_pulse <= 1'b0;
        end else begin
            dma_rd_pulse <= ior_fall && dack_lo;
            dma_wr_pulse <= iow_fall && dack_lo;
        end
    end

    // Bus drive enable: set at a qualified read edge, released once the strobe is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_q <= 1'b0;
        end else if (ior_fall && (pio_hit || dack_lo)) begin
            oe_q <= 1'b1;
        end else if (ior_hi) begin
            oe_q <= 1'b0;
        end
    end

    assign data_oe   = oe_q;
    assign host_dout = per_rdata;

    AST_OE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (data_oe && ior_hi) |=> !data_oe);  // R5
    AST_DMA_PULSE_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_rd_pulse || dma_wr_pulse) |-> $past(dack_lo));  // R9
endmodule

// File: tb/hbus_dma_front_tb.sv
module hbus_dma_front_tb;
    localparam int unsigned K_NONE = 0, K_REGRD = 1, K_REGWR = 2,
                            K_DMARD = 3, K_DMAWR = 4, K_TC = 5;

    typedef struct packed {
        logic [2:0] kind;
        logic [2:0] idx;
        logic [7:0] data;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ior_n = 1'b1, iow_n = 1'b1, aen = 1'b0;
    logic [9:0] addr = '0, io_base = 10'h3F0;
    logic [7:0] host_din = '0, per_rdata = 8'hA5;
    logic dack_n = 1'b1, tc_in = 1'b0, tc_pol = 1'b0, byte_req = 1'b0, rearm = 1'b0;
    logic [7:0] host_dout, reg_wdata;
    logic [2:0] reg_idx;
    logic data_oe, reg_rd_pulse, reg_wr_pulse, dma_rd_pulse, dma_wr_pulse, drq, tc_done;

    int checks = 0;
    int errors = 0;
    exp_t sb_q[$];

    always #10 clk = ~clk;

    hbus_dma_front u_dut (
        .clk(clk), .rst_n(rst_n), .ior_n(ior_n), .iow_n(iow_n), .aen(aen),
        .addr(addr), .io_base(io_base), .host_din(host_din), .host_dout(host_dout),
        .data_oe(data_oe), .dack_n(dack_n), .tc_in(tc_in), .tc_pol(tc_pol),
        .byte_req(byte_req), .rearm(rearm), .per_rdata(per_rdata),
        .reg_rd_pulse(reg_rd_pulse), .reg_wr_pulse(reg_wr_pulse), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .dma_rd_pulse(dma_rd_pulse), .dma_wr_pulse(dma_wr_pulse),
        .drq(drq), .tc_done(tc_done)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic push(input int unsigned kind, input logic [2:0] idx, input logic [7:0] d);
        exp_t e;
        e.kind = 3'(kind);
        e.idx  = idx;
        e.data = d;
        sb_q.push_back(e);
    endtask

    // Monitor: pop one expected item for every pulse the design produces.
    task automatic observe(input int unsigned kind, input string req);
        exp_t e;
        if (sb_q.size() == 0) begin
            check({req, " unexpected pulse"}, kind, K_NONE);
        end else begin
            e = sb_q.pop_front();
            check({req, " pulse kind"}, kind, 32'(e.kind));
            if (kind == K_REGRD || kind == K_REGWR)
                check({req, " reg_idx"}, 32'(reg_idx), 32'(e.idx));
            if (kind == K_REGWR)
                check({req, " reg_wdata"}, 32'(reg_wdata), 32'(e.data));
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (reg_rd_pulse) observe(K_REGRD, "R2/R4");
            if (reg_wr_pulse) observe(K_REGWR, "R3/R4");
            if (dma_rd_pulse) observe(K_DMARD, "R9");
            if (dma_wr_pulse) observe(K_DMAWR, "R9");
            if (tc_done)      observe(K_TC, "R10/R11");
        end
    end

    // Driver: one host strobe cycle; expected pulse pushed before the stimulus.
    task automatic bus_cycle(input bit wr, input logic [9:0] a, input logic aen_v,
                             input logic [7:0] d, input int unsigned exp_kind,
                             input logic exp_oe, input string req);
        @(negedge clk);
        addr = a; aen = aen_v; host_din = d;
        if (exp_kind != K_NONE) push(exp_kind, a[2:0], d);
        repeat (2) @(negedge clk);
        if (wr) iow_n = 1'b0; else ior_n = 1'b0;
        repeat (6) @(negedge clk);
        if (!wr) begin
            check({req, " R5 data_oe during read"}, 32'(data_oe), 32'(exp_oe));
            if (exp_oe) check("R5 host_dout", 32'(host_dout), 32'(per_rdata));
        end
        ior_n = 1'b1; iow_n = 1'b1;
        repeat (5) @(negedge clk);
        check({req, " R5 data_oe released"}, 32'(data_oe), 32'd0);
    endtask

    task automatic pulse_byte_req();
        @(negedge clk); byte_req = 1'b1;
        @(negedge clk); byte_req = 1'b0;
    endtask

    initial begin
        #4_000_000;
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        check("R1 drq in reset", 32'(drq), 32'd0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R1 drq after reset", 32'(drq), 32'd0);
        check("R1 data_oe after reset", 32'(data_oe), 32'd0);
        check("R1 pulses after reset",
              32'({reg_rd_pulse, reg_wr_pulse, dma_rd_pulse, dma_wr_pulse, tc_done}), 32'd0);

        // R2 / R3: decoded programmed reads and writes
        bus_cycle(1'b0, 10'h3F5, 1'b0, 8'h00, K_REGRD, 1'b1, "R2 read idx5");
        bus_cycle(1'b0, 10'h3F0, 1'b0, 8'h00, K_REGRD, 1'b1, "R2 read idx0");
        bus_cycle(1'b1, 10'h3F2, 1'b0, 8'h3C, K_REGWR, 1'b0, "R3 write idx2");
        bus_cycle(1'b1, 10'h3F7, 1'b0, 8'hC3, K_REGWR, 1'b0, "R3 write idx7");
        // R4: mismatch and aen high give no register pulse and no drive
        bus_cycle(1'b0, 10'h3E5, 1'b0, 8'h00, K_NONE, 1'b0, "R4 read mismatch");
        bus_cycle(1'b0, 10'h3F1, 1'b1, 8'h00, K_NONE, 1'b0, "R4 read aen high");
        bus_cycle(1'b1, 10'h3F3, 1'b1, 8'h55, K_NONE, 1'b0, "R4 write aen high");
        bus_cycle(1'b1, 10'h1F3, 1'b0, 8'h55, K_NONE, 1'b0, "R4 write mismatch");

        // R9: acknowledged cycles without decode
        @(negedge clk); dack_n = 1'b0;
        repeat (4) @(negedge clk);
        bus_cycle(1'b0, 10'h123, 1'b1, 8'h00, K_DMARD, 1'b1, "R9 dma read");
        bus_cycle(1'b1, 10'h2AA, 1'b1, 8'h77, K_DMAWR, 1'b0, "R9 dma write");
        @(negedge clk); dack_n = 1'b1;
        repeat (4) @(negedge clk);

        // R6 / R7: normal request, dropped by acknowledge fall
        pulse_byte_req();
        check("R6 drq raised", 32'(drq), 32'd1);
        repeat (5) @(negedge clk);
        check("R7 drq held before ack", 32'(drq), 32'd1);
        dack_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R7 drq before sync ack edge", 32'(drq), 32'd1);
        @(negedge clk);
        check("R7 drq cleared by ack fall", 32'(drq), 32'd0);
        bus_cycle(1'b0, 10'h000, 1'b1, 8'h00, K_DMARD, 1'b1, "R9 dma read after drq");
        @(negedge clk); dack_n = 1'b1;
        repeat (4) @(negedge clk);

        // R8: demand mode, acknowledge already low
        dack_n = 1'b0; aen = 1'b1;
        repeat (5) @(negedge clk);
        pulse_byte_req();
        check("R8 drq raised in demand mode", 32'(drq), 32'd1);
        repeat (6) @(negedge clk);
        check("R8 drq held with ack low", 32'(drq), 32'd1);
        push(K_DMARD, 3'd0, 8'h00);
        ior_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R8 drq before sync read edge", 32'(drq), 32'd1);
        @(negedge clk);
        check("R8 drq cleared by read fall", 32'(drq), 32'd0);
        repeat (2) @(negedge clk);
        ior_n = 1'b1;
        repeat (4) @(negedge clk);
        dack_n = 1'b1; aen = 1'b0;
        repeat (4) @(negedge clk);

        // R10: terminal count with acknowledge high has no effect
        tc_in = 1'b1;
        repeat (6) @(negedge clk);
        tc_in = 1'b0;
        repeat (4) @(negedge clk);
        pulse_byte_req();
        check("R10 still armed after ignored tc", 32'(drq), 32'd1);
        dack_n = 1'b0;
        repeat (4) @(negedge clk);
        check("R10 drq cleared", 32'(drq), 32'd0);

        // R11 active-high terminal count inside acknowledged period
        push(K_TC, 3'd0, 8'h00);
        tc_in = 1'b1;
        repeat (8) @(negedge clk);
        tc_in = 1'b0;
        repeat (3) @(negedge clk);
        dack_n = 1'b1;
        repeat (4) @(negedge clk);

        // R12: disarmed until rearm
        pulse_byte_req();
        @(negedge clk);
        check("R12 no drq while disarmed", 32'(drq), 32'd0);
        rearm = 1'b1;
        @(negedge clk); rearm = 1'b0;
        pulse_byte_req();
        check("R12 drq after rearm", 32'(drq), 32'd1);
        dack_n = 1'b0;
        repeat (4) @(negedge clk);
        check("R7 drq cleared after rearm", 32'(drq), 32'd0);
        dack_n = 1'b1;
        repeat (4) @(negedge clk);

        // R11 active-low terminal count
        tc_pol = 1'b1; tc_in = 1'b1;
        repeat (4) @(negedge clk);
        tc_in = 1'b0;
        repeat (5) @(negedge clk);
        tc_in = 1'b1;
        repeat (4) @(negedge clk);
        dack_n = 1'b0;
        repeat (5) @(negedge clk);
        push(K_TC, 3'd0, 8'h00);
        tc_in = 1'b0;
        repeat (8) @(negedge clk);
        tc_in = 1'b1;
        repeat (3) @(negedge clk);
        dack_n = 1'b1;
        repeat (4) @(negedge clk);
        pulse_byte_req();
        @(negedge clk);
        check("R12 no drq after active-low tc", 32'(drq), 32'd0);

        repeat (4) @(negedge clk);
        check("R2 R9 R11 scoreboard drained", 32'(sb_q.size()), 32'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule